// File: doc/BRIEF.md
# Single-Error-Correcting State Machine

This block is a small control sequencer whose binary-coded 4-bit state lives in a 7-bit register. Three check bits sit alongside the state bits, so any two stored words differ in at least three bit positions. Every cycle a decoder works out the syndrome of the stored word, flips the one bit it points at, and hands the repaired state to the next-state logic and the output decode. The register always reloads a freshly encoded word. As a result, a single upset is gone after the next clock edge, whether the machine is advancing or stalled.

The sequencer waits in an idle state. A start request arms it. It then fires for one cycle and holds until a stop request, reports completion for one cycle, and returns to idle. A stop while armed aborts back to idle. A load enable gates the advance. When the enable is low, the register reloads the corrected present state, so a repair is never postponed. An upset-injection input inverts chosen codeword bits as they are written, which lets the protection be exercised at the ports. The asynchronous reset loads a complete, consistent codeword, so the check bits never disagree with the state after reset.

Top module: `ham_fsm`

## Requirements
- R1: While `rst_n` is low, asynchronously and without waiting for a clock, `state_o` reads 0000 (idle) and `fix_o` reads 0. Reset loads state and check bits as one consistent word.
- R2: With `en_i` high, each rising edge moves the state as follows. From idle (0000), `start_i` goes to armed (0011); otherwise it stays idle. From armed, `stop_i` goes back to idle; otherwise it goes to fire (0101). Fire always goes to hold (0110). From hold, `stop_i` goes to done (1111); otherwise it stays in hold. Done always goes to idle.
- R3: With `en_i` low, the state does not change on a clock edge.
- R4: `busy_o` is 1 in armed, fire and hold. `fire_o` is 1 only in fire. `done_o` is 1 only in done. `state_o` shows the corrected state code.
- R5: `flip_i` bit j inverts codeword position j+1 as the word is written at a rising edge. Positions 3, 5, 6 and 7 hold state bits 0 to 3. Positions 1, 2 and 4 hold the check bits.
- R6: An upset in any one of the 7 positions does not change `state_o` or the decoded outputs.
- R7: `fix_o` is high during the cycle after an edge that stored a single-bit upset. It is low again after the following edge, provided no new upset is injected.
- R8: Repair also takes place while `en_i` is low. Single upsets injected on successive edges into different bits are each corrected and do not combine.
- R9: When an upset is stored while the machine advances, the next transition is taken from the corrected state.
- R10: `fix_o` stays low when no upset has been injected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Load enable for state advance |
| start_i | input | 1 | Start request |
| stop_i | input | 1 | Stop / abort request |
| flip_i | input | 7 | Upset injection, bit j inverts codeword position j+1 |
| state_o | output | 4 | Corrected present state code |
| busy_o | output | 1 | Armed, firing or holding |
| fire_o | output | 1 | One-cycle fire indication |
| done_o | output | 1 | One-cycle completion indication |
| fix_o | output | 1 | Single-bit error corrected in this cycle |

## Verification
The state register is the only storage, so a transition or an injected upset shows on `state_o` and the decoded outputs one edge after it is driven, and `fix_o` rises in that same cycle. `fix_o` must drop one edge later, once the register has reloaded a clean word. The bench drives inputs after a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Each upset is therefore checked twice: once for the pulse with the correct state, and once more for the cleared pulse. Reset is checked one time step after it falls, with no clock edge in between.

// File: rtl/ham_fsm.sv
module ham_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [6:0] flip_i,
  output logic [3:0] state_o,
  output logic       busy_o,
  output logic       fire_o,
  output logic       done_o,
  output logic       fix_o
);

  localparam int SW = 4;

  function automatic int calc_k(input int n);
    int r;
    r = 0;
    for (int k = 8; k >= 1; k--)
      if ((1 << k) >= n + k + 1) r = k;
    return r;
  endfunction

  localparam int CK = calc_k(SW);
  localparam int CW = SW + CK;

  function automatic int dpos(input int i);
    int cnt, r;
    cnt = 0;
    r = 1;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        if (cnt == i) r = p;
        cnt++;
      end
    return r;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [SW-1:0] s);
    logic [CW-1:0] cw;
    logic par;
    cw = '0;
    for (int i = 0; i < SW; i++) cw[dpos(i)-1] = s[i];
    for (int c = 0; c < CK; c++) begin
      par = 1'b0;
      for (int p = 1; p <= CW; p++)
        if (((p >> c) & 1) == 1 && p != (1 << c)) par = par ^ cw[p-1];
      cw[(1 << c)-1] = par;
    end
    return cw;
  endfunction

  typedef enum logic [SW-1:0] {
    S_IDLE = 4'b0000,
    S_ARM  = 4'b0011,
    S_FIRE = 4'b0101,
    S_HOLD = 4'b0110,
    S_DONE = 4'b1111
  } st_t;

  localparam logic [CW-1:0] RST_CODE = encode(S_IDLE);

  logic [CW-1:0] code_q, fixed_code;
  logic [CK-1:0] syn;
  logic [SW-1:0] cur_s, nxt_s, d_s;

  // syndrome: stored checks against checks rebuilt from stored state
  always_comb begin
    for (int c = 0; c < CK; c++) begin
      syn[c] = 1'b0;
      for (int p = 1; p <= CW; p++)
        if (((p >> c) & 1) == 1) syn[c] = syn[c] ^ code_q[p-1];
    end
    fixed_code = code_q;
    if (syn != '0 && int'(syn) <= CW)
      fixed_code[int'(syn)-1] = ~code_q[int'(syn)-1];
    for (int i = 0; i < SW; i++) cur_s[i] = fixed_code[dpos(i)-1];
  end

  always_comb begin
    case (cur_s)
      S_IDLE:  nxt_s = start_i ? S_ARM : S_IDLE;
      S_ARM:   nxt_s = stop_i ? S_IDLE : S_FIRE;
      S_FIRE:  nxt_s = S_HOLD;
      S_HOLD:  nxt_s = stop_i ? S_DONE : S_HOLD;
      S_DONE:  nxt_s = S_IDLE;
      default: nxt_s = S_IDLE;
    endcase
  end

  // enable folded into the data path: stalled cycles rewrite the repaired word
  assign d_s = en_i ? nxt_s : cur_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= RST_CODE;
    else        code_q <= encode(d_s) ^ flip_i;
  end

  assign state_o = cur_s;
  assign busy_o  = (cur_s == S_ARM) || (cur_s == S_FIRE) || (cur_s == S_HOLD);
  assign fire_o  = (cur_s == S_FIRE);
  assign done_o  = (cur_s == S_DONE);
  assign fix_o   = |syn;

endmodule

module ham_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic [6:0] flip_i,
  input logic [3:0] state_o,
  input logic       fire_o,
  input logic       fix_o
);

  assert_legal_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o inside {4'b0000, 4'b0011, 4'b0101, 4'b0110, 4'b1111});

  assert_fire_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fire_o) |=> !fire_o);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state_o == $past(state_o)));

  assert_fix_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_o && flip_i == 7'd0) |=> !fix_o);

  assert_no_false_fix_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flip_i) == 7'd0) |-> !fix_o);

endmodule

bind ham_fsm ham_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .flip_i(flip_i),
  .state_o(state_o), .fire_o(fire_o), .fix_o(fix_o)
);

// File: tb/ham_fsm_test.sv
`timescale 1ns/1ps
module ham_fsm_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b1;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [6:0] flip_i = 7'd0;
  logic [3:0] state_o;
  logic       busy_o, fire_o, done_o, fix_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [3:0] IDLE = 4'b0000, ARM = 4'b0011, FIRE = 4'b0101,
                         HOLD = 4'b0110, DONE = 4'b1111;

  always #2.5 clk = ~clk;

  ham_fsm uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i), .stop_i(stop_i),
    .flip_i(flip_i), .state_o(state_o), .busy_o(busy_o), .fire_o(fire_o),
    .done_o(done_o), .fix_o(fix_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(input string req, input logic [3:0] exp);
    check(req, {28'd0, state_o}, {28'd0, exp});
    check({req, " busy"}, {31'd0, busy_o}, {31'd0, (exp == ARM || exp == FIRE || exp == HOLD)});
    check({req, " fire"}, {31'd0, fire_o}, {31'd0, (exp == FIRE)});
    check({req, " done"}, {31'd0, done_o}, {31'd0, (exp == DONE)});
  endtask

  task automatic go_hold();
    en_i = 1'b1; stop_i = 1'b0; start_i = 1'b1;
    step();
    start_i = 1'b0;
    step(); step();
    check_state("R2 reach hold", HOLD);
  endtask

  task automatic go_idle();
    en_i = 1'b1; start_i = 1'b0; stop_i = 1'b1;
    step(); step();
    stop_i = 1'b0;
    step();
    check_state("R2 back to idle", IDLE);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    check_state("R1 reset state", IDLE);
    check("R1 reset fix", {31'd0, fix_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check_state("R1 idle after release", IDLE);
    check("R10 no fix after reset", {31'd0, fix_o}, 32'd0);
  endtask

  task automatic t_sequence();
    en_i = 1'b1; start_i = 1'b0; stop_i = 1'b0;
    step();
    check_state("R2 idle waits", IDLE);
    start_i = 1'b1;
    step();
    check_state("R2 R4 armed", ARM);
    start_i = 1'b0;
    step();
    check_state("R2 R4 fire", FIRE);
    step();
    check_state("R2 R4 hold", HOLD);
    step();
    check_state("R2 hold stays", HOLD);
    stop_i = 1'b1;
    step();
    check_state("R2 R4 done", DONE);
    stop_i = 1'b0;
    step();
    check_state("R2 done to idle", IDLE);
    start_i = 1'b1;
    step();
    start_i = 1'b0; stop_i = 1'b1;
    step();
    check_state("R2 abort from armed", IDLE);
    stop_i = 1'b0;
    check("R10 no fix in normal run", {31'd0, fix_o}, 32'd0);
  endtask

  task automatic t_stall();
    en_i = 1'b1; start_i = 1'b1;
    step();
    start_i = 1'b0; en_i = 1'b0;
    step(); step(); step();
    check_state("R3 stalled in armed", ARM);
    en_i = 1'b1;
    step();
    check_state("R3 resumes to fire", FIRE);
    step();
    go_idle();
  endtask

  task automatic t_each_pos();
    go_hold();
    for (int pos = 1; pos <= 7; pos++) begin
      flip_i = 7'd1 << (pos - 1);
      step();
      flip_i = 7'd0;
      check_state($sformatf("R5 R6 upset pos %0d state", pos), HOLD);
      check($sformatf("R7 fix pulse pos %0d", pos), {31'd0, fix_o}, 32'd1);
      step();
      check($sformatf("R7 fix clears pos %0d", pos), {31'd0, fix_o}, 32'd0);
      check_state($sformatf("R6 repaired pos %0d", pos), HOLD);
    end
    go_idle();
  endtask

  task automatic t_advance();
    en_i = 1'b1; start_i = 1'b1;
    flip_i = 7'b0010000;
    step();
    flip_i = 7'd0; start_i = 1'b0;
    check_state("R9 armed with upset", ARM);
    check("R9 fix pulse", {31'd0, fix_o}, 32'd1);
    flip_i = 7'b1000000;
    step();
    flip_i = 7'd0;
    check_state("R9 fire from corrected", FIRE);
    check("R9 fix again", {31'd0, fix_o}, 32'd1);
    step();
    check_state("R9 hold", HOLD);
    check("R9 fix clear", {31'd0, fix_o}, 32'd0);
    go_idle();
  endtask

  task automatic t_accumulate();
    go_hold();
    en_i = 1'b0;
    flip_i = 7'b0000100;
    step();
    check_state("R8 stalled first upset", HOLD);
    check("R8 fix first", {31'd0, fix_o}, 32'd1);
    flip_i = 7'b0100000;
    step();
    check_state("R8 stalled second upset", HOLD);
    check("R8 fix second", {31'd0, fix_o}, 32'd1);
    flip_i = 7'b0001000;
    step();
    flip_i = 7'd0;
    check_state("R8 stalled third upset", HOLD);
    step();
    check("R8 fix clears while stalled", {31'd0, fix_o}, 32'd0);
    check_state("R8 still hold", HOLD);
    en_i = 1'b1; stop_i = 1'b1;
    step();
    stop_i = 1'b0;
    check_state("R8 clean advance to done", DONE);
    step();
    check_state("R8 back to idle", IDLE);
  endtask

  task automatic t_async_reset();
    go_hold();
    #1 rst_n = 1'b0;
    #1;
    check_state("R1 async reset mid run", IDLE);
    check("R1 async reset fix", {31'd0, fix_o}, 32'd0);
    step();
    rst_n = 1'b1;
    step();
    check_state("R1 idle after async reset", IDLE);
    check("R10 no fix after async reset", {31'd0, fix_o}, 32'd0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequence();
    t_stall();
    t_each_pos();
    t_advance();
    t_accumulate();
    t_async_reset();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule